// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block sits between the core's port logic and one bidirectional pad with a pull-up. It holds three scan stages, each followed by an update latch. The stage next to the scan input is shared by two signals: it captures the pad level and later supplies the test value driven onto the pad. The middle stage holds the output-enable value. The last stage holds the pull-up-enable value and feeds the scan output.

The core gives the cell a pull-up-disable bit, a direction bit and a port bit. The core's pull-up request is formed from these three bits inside the cell. During normal operation and during sampling, the pad follows the core. When the external-test control is high, the update latches drive the pad instead of the core. The pad level always passes straight through to the core.

The cell has no streaming data, so all of its pins are plain levels sampled on the test clock. Capture and shift happen on the rising edge when the data-register clock enable is high. Update happens on the falling edge when the update control is high.

Top module: `pinscan_bidir_cell`

## Requirements
- R1: While `rst_n` is low, all three stages and all three update latches are 0. As a result, `scan_out` is 0, and with `extest` high the pad drive signals are all 0.
- R2: While `extest` is 0, `pad_oe` equals `core_ddr` and `pad_out` equals `core_port`.
- R3: While `extest` is 0, `pad_pue` equals (not `core_pud`) and (not `core_ddr`) and `core_port`.
- R4: `core_id` equals `pad_in` at all times, in every mode.
- R5: A rising `tck` edge with `clock_dr`=1 and `shift_dr`=0 captures three values. Stage 0 takes `pad_in`, stage 1 takes `core_ddr`, and stage 2 takes the core pull-up request from R3. `scan_out` shows stage 2.
- R6: A rising `tck` edge with `clock_dr`=1 and `shift_dr`=1 shifts the chain `scan_in` → stage 0 → stage 1 → stage 2 → `scan_out`. A bit shifted in appears on `scan_out` after three shifts.
- R7: While `clock_dr` is 0, the stages hold their values and `scan_out` does not change.
- R8: A falling `tck` edge with `update_dr`=1 copies the stages into the latches. Stage 0 goes to the data latch, stage 1 to the enable latch and stage 2 to the pull-up latch. At any other time the latches hold.
- R9: While `extest` is 1, the pad is driven only from the latches: `pad_out` from the data latch, `pad_oe` from the enable latch and `pad_pue` from the pull-up latch. The core signals have no effect on the pad. With the enable latch at 0 the pad is released, and the pull-up still follows its latch.
- R10: An update made while `extest` is 0 does not change the pad drive. The loaded values appear on the pad once `extest` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| clock_dr | input | 1 | Data-register clock enable (capture or shift) |
| shift_dr | input | 1 | Selects shift (1) or capture (0) |
| update_dr | input | 1 | Copies the stages into the latches on the falling edge |
| extest | input | 1 | Latches drive the pad when high |
| scan_in | input | 1 | Serial input from the previous cell |
| scan_out | output | 1 | Serial output to the next cell (stage 2) |
| core_pud | input | 1 | Core global pull-up disable |
| core_ddr | input | 1 | Core direction bit (1 = output) |
| core_port | input | 1 | Core port data bit |
| pad_in | input | 1 | Level observed on the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| pad_pue | output | 1 | Pad pull-up enable |
| core_id | output | 1 | Pad level passed to the core |

## Verification
Four properties are checked on every cycle:
- Outside external test, the pad follows the core direction, data and pull-up request.
- The pad level passes straight through to `core_id`.
- A bit shifted in three times in a row arrives on `scan_out`.
- The pad drive stays still in external test when no update is requested.

Only the bench scenarios can show what was captured, because captured values become visible only after they are shifted out. The same holds for the mapping of each stage to its latch, and for values loaded during sampling that appear only after `extest` rises. A behavioural reference model compares every output on every cycle. It covers both the directed sequences and a long run of random control and pin activity.

// File: rtl/pinscan_pkg.sv
package pinscan_pkg;
  localparam int unsigned CELL_STAGES = 3;
  localparam int unsigned IDX_DATA    = 0;
  localparam int unsigned IDX_CTRL    = 1;
  localparam int unsigned IDX_PULL    = 2;

  typedef struct packed {
    logic pue;
    logic oe;
    logic dout;
  } pin_drive_t;
endpackage

// File: rtl/pinscan_shift.sv
module pinscan_shift #(
  parameter int unsigned N = 3
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         clock_dr,
  input  logic         shift_dr,
  input  logic         scan_in,
  input  logic [N-1:0] capture,
  output logic [N-1:0] stage_q,
  output logic         scan_out
);
  localparam int unsigned LAST = N - 1;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic prev;
    logic q;
    if (i == 0) begin : g_head
      assign prev = scan_in;
    end else begin : g_link
      assign prev = stage_q[i-1];
    end
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (clock_dr) q <= shift_dr ? prev : capture[i];
    end
    assign stage_q[i] = q;
  end

  assign scan_out = stage_q[LAST];
endmodule

// File: rtl/pinscan_update.sv
module pinscan_update #(
  parameter int unsigned N = 3
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         update_dr,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (update_dr) q <= d;
  end
endmodule

// File: rtl/pinscan_drive_mux.sv
module pinscan_drive_mux
  import pinscan_pkg::*;
(
  input  logic       extest,
  input  pin_drive_t from_core,
  input  pin_drive_t from_latch,
  output pin_drive_t to_pad
);
  always_comb begin
    if (extest) to_pad = from_latch;
    else        to_pad = from_core;
  end
endmodule

// File: rtl/pinscan_bidir_cell.sv
module pinscan_bidir_cell
  import pinscan_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic clock_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic extest,
  input  logic scan_in,
  output logic scan_out,
  input  logic core_pud,
  input  logic core_ddr,
  input  logic core_port,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pue,
  output logic core_id
);
  localparam int unsigned N = CELL_STAGES;

  logic [N-1:0] capture_vec;
  logic [N-1:0] stage_q;
  logic [N-1:0] latch_q;
  logic         core_pull_req;
  pin_drive_t   core_drive;
  pin_drive_t   latch_drive;
  pin_drive_t   pad_drive;

  assign core_pull_req = ~core_pud & ~core_ddr & core_port;

  always_comb begin
    capture_vec           = '0;
    capture_vec[IDX_DATA] = pad_in;
    capture_vec[IDX_CTRL] = core_ddr;
    capture_vec[IDX_PULL] = core_pull_req;
  end

  pinscan_shift #(.N(N)) u_shift (
    .tck      (tck),
    .rst_n    (rst_n),
    .clock_dr (clock_dr),
    .shift_dr (shift_dr),
    .scan_in  (scan_in),
    .capture  (capture_vec),
    .stage_q  (stage_q),
    .scan_out (scan_out)
  );

  pinscan_update #(.N(N)) u_update (
    .tck       (tck),
    .rst_n     (rst_n),
    .update_dr (update_dr),
    .d         (stage_q),
    .q         (latch_q)
  );

  assign core_drive  = '{pue: core_pull_req, oe: core_ddr, dout: core_port};
  assign latch_drive = '{pue: latch_q[IDX_PULL], oe: latch_q[IDX_CTRL],
                         dout: latch_q[IDX_DATA]};

  pinscan_drive_mux u_mux (
    .extest     (extest),
    .from_core  (core_drive),
    .from_latch (latch_drive),
    .to_pad     (pad_drive)
  );

  assign pad_oe  = pad_drive.oe;
  assign pad_out = pad_drive.dout;
  assign pad_pue = pad_drive.pue;
  assign core_id = pad_in;
endmodule

// File: rtl/pinscan_bidir_cell_chk.sv
module pinscan_bidir_cell_chk (
  input logic tck,
  input logic rst_n,
  input logic clock_dr,
  input logic shift_dr,
  input logic update_dr,
  input logic extest,
  input logic scan_in,
  input logic scan_out,
  input logic core_pud,
  input logic core_ddr,
  input logic core_port,
  input logic pad_in,
  input logic pad_oe,
  input logic pad_out,
  input logic pad_pue,
  input logic core_id
);
  logic shifting;
  assign shifting = clock_dr & shift_dr;

  AST_RESET_CLEARS_CHAIN: assert property (@(posedge tck)
    !rst_n |-> (scan_out == 1'b0)); // R1

  AST_CORE_OWNS_PAD: assert property (@(posedge tck) disable iff (!rst_n)
    !extest |-> (pad_oe == core_ddr && pad_out == core_port)); // R2

  AST_PULLUP_FROM_CORE: assert property (@(posedge tck) disable iff (!rst_n)
    !extest |-> (pad_pue == (!core_pud && !core_ddr && core_port))); // R3

  AST_INPUT_PASSTHRU: assert property (@(posedge tck) disable iff (!rst_n)
    core_id == pad_in); // R4

  AST_THREE_SHIFT_LATENCY: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(shifting, 1) && $past(shifting, 2) && $past(shifting, 3))
      |-> (scan_out == $past(scan_in, 3))); // R6

  AST_LATCH_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    (extest && $past(extest) && !update_dr)
      |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pue))); // R8
endmodule

bind pinscan_bidir_cell pinscan_bidir_cell_chk u_chk (
  .tck(tck), .rst_n(rst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .extest(extest), .scan_in(scan_in),
  .scan_out(scan_out), .core_pud(core_pud), .core_ddr(core_ddr),
  .core_port(core_port), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pue(pad_pue), .core_id(core_id)
);

// File: tb/tb_pinscan_bidir_cell.sv
`timescale 1ns/1ps
module tb_pinscan_bidir_cell;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic clock_dr = 0, shift_dr = 0, update_dr = 0, extest = 0, scan_in = 0;
  logic core_pud = 0, core_ddr = 0, core_port = 0, pad_in = 0;
  logic scan_out, pad_oe, pad_out, pad_pue, core_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int st[3];
  int ld[3];

  pinscan_bidir_cell dut (
    .tck(tck), .rst_n(rst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .extest(extest), .scan_in(scan_in),
    .scan_out(scan_out), .core_pud(core_pud), .core_ddr(core_ddr),
    .core_port(core_port), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pue(pad_pue), .core_id(core_id)
  );

  always #4 tck = ~tck;

  // Reference model: stage 0 near scan_in, stage 2 feeds scan_out.
  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) st[i] = 0;
    end else if (clock_dr) begin
      if (shift_dr) begin
        st[2] = st[1]; st[1] = st[0]; st[0] = int'(scan_in);
      end else begin
        st[0] = int'(pad_in);
        st[1] = int'(core_ddr);
        st[2] = (!core_pud && !core_ddr && core_port) ? 1 : 0;
      end
    end
  end

  always @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) ld[i] = 0;
    end else if (update_dr) begin
      for (int i = 0; i < 3; i++) ld[i] = st[i];
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, after the falling edge and before the next rise.
  initial begin
    forever begin
      @(posedge tck);
      #6;
      if (rst_n) begin
        logic e_pue;
        e_pue = !core_pud && !core_ddr && core_port;
        check("R6 scan_out model", scan_out, st[2] != 0);
        check("R4 core_id", core_id, pad_in);
        if (extest) begin
          check("R9 pad_out", pad_out, ld[0] != 0);
          check("R9 pad_oe",  pad_oe,  ld[1] != 0);
          check("R9 pad_pue", pad_pue, ld[2] != 0);
        end else begin
          check("R2 pad_out", pad_out, core_port);
          check("R2 pad_oe",  pad_oe,  core_ddr);
          check("R3 pad_pue", pad_pue, e_pue);
        end
      end
    end
  end

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  task automatic idle();
    clock_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    extest = 1;
    repeat (3) tick();
    #4;
    check("R1 scan_out in reset", scan_out, 1'b0);
    check("R1 pad_oe in reset", pad_oe, 1'b0);
    check("R1 pad_out in reset", pad_out, 1'b0);
    check("R1 pad_pue in reset", pad_pue, 1'b0);
    tick();
    rst_n = 1; extest = 0;
    tick();

    // R5: capture pad=1, ddr=0, pull request=1 -> stages {1,0,1}
    pad_in = 1; core_ddr = 0; core_pud = 0; core_port = 1;
    clock_dr = 1; shift_dr = 0;
    #4; check("R4 core_id direct", core_id, 1'b1);
    tick();
    shift_dr = 1; scan_in = 0; pad_in = 0; core_port = 0;
    #4; check("R5 captured pull stage", scan_out, 1'b1);
    tick();
    #4; check("R5 captured ctrl stage", scan_out, 1'b0);
    tick();
    idle();
    #4; check("R5 captured data stage", scan_out, 1'b1);
    // R7: no clock_dr, chain holds
    tick(); tick();
    #4; check("R7 hold without clock_dr", scan_out, 1'b1);

    // Load pull=0, ctrl=1, data=1 (first bit shifted lands in stage 2)
    tick();
    clock_dr = 1; shift_dr = 1; scan_in = 0;
    tick(); scan_in = 1;
    tick(); scan_in = 1;
    tick(); idle();
    // R10: update under sampling leaves pad on the core
    core_ddr = 0; core_port = 0; core_pud = 1;
    update_dr = 1;
    #4;
    check("R10 pad_oe under sample", pad_oe, 1'b0);
    check("R10 pad_out under sample", pad_out, 1'b0);
    tick(); idle();
    extest = 1;
    #4;
    check("R8 data latch to pad_out", pad_out, 1'b1);
    check("R8 ctrl latch to pad_oe", pad_oe, 1'b1);
    check("R9 pull latch to pad_pue", pad_pue, 1'b0);
    // R9: core changes ignored in external test
    tick();
    core_ddr = 1; core_port = 1; core_pud = 0;
    #4; check("R9 core ignored pad_out", pad_out, 1'b1);
    // R8: shifting without update leaves latches alone
    tick();
    clock_dr = 1; shift_dr = 1; scan_in = 1;
    tick(); scan_in = 0;
    tick(); scan_in = 0;
    tick(); idle();
    #4;
    check("R8 hold without update oe", pad_oe, 1'b1);
    check("R8 hold without update pue", pad_pue, 1'b0);
    // stages now data=0, ctrl=0, pull=1 -> pad released, pull-up on
    tick(); update_dr = 1;
    #4;
    check("R9 released pad_oe", pad_oe, 1'b0);
    check("R9 pull follows latch", pad_pue, 1'b1);
    check("R8 new data latch", pad_out, 1'b0);
    tick(); idle();

    // Random run checked against the model each cycle
    for (int n = 0; n < 3000; n++) begin
      tick();
      clock_dr  = $urandom_range(0, 1);
      shift_dr  = $urandom_range(0, 1);
      update_dr = ($urandom_range(0, 3) == 0);
      extest    = ($urandom_range(0, 7) != 0) ? extest : ~extest;
      scan_in   = $urandom_range(0, 1);
      core_pud  = $urandom_range(0, 1);
      core_ddr  = $urandom_range(0, 1);
      core_port = $urandom_range(0, 1);
      pad_in    = $urandom_range(0, 1);
    end
    tick(); idle();
    tick(); tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule